// File: doc/BRIEF.md
# Byte-Serial Peripheral Master with Completion and Collision Flags

This block is a serial peripheral interface master that sits behind a small register bus with three addresses: control, status and data. Software writes a byte to the data address and the block clocks it out on MOSI, most significant bit first, while it collects the byte coming back on MISO. The serial clock comes from the system clock through a two-bit rate select. A double-speed bit in the status register halves every divisor.

When a byte has been shifted, a completion flag is raised. It can drive an interrupt request that is qualified by a local enable and by a global enable input. An acknowledge input clears the flag. Software can also clear it by reading the status register while a flag is set and then touching the data register. A data write during a transfer is dropped and raises a collision flag. A slave-select input can be configured as an input. If it is pulled low while the block is master, the block is forced out of master mode, any shift in progress is aborted and the completion flag is set.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) read 0x00, and the serial clock is low.
- R2: With the double-speed bit at 0, rate-select code 0/1/2/3 (control bits 1:0) gives a serial clock of system clock divided by 4/16/64/128. A byte therefore takes 8 serial periods, counted from the data write to the completion flag.
- R3: With the double-speed bit (status bit 0) at 1, the same codes divide by 2/8/32/64.
- R4: Serial mode 0 is used. The clock idles low, MOSI presents bits MSB first and changes on falling edges, and MISO is sampled on rising edges. The received byte is read at address 2.
- R5: The completion flag is status bit 7 and is set when the eighth bit has been shifted. The interrupt request equals completion flag AND interrupt enable (control bit 7) AND the global enable input.
- R6: A one-cycle pulse on the acknowledge input clears the completion flag.
- R7: A data-register access clears the completion flag and the collision flag only if it follows a status read that saw one of them set. A data access without such a read leaves both flags unchanged.
- R8: A data write while a transfer is running sets the collision flag (status bit 6) and does not alter the byte being shifted.
- R9: When the block is enabled (control bit 6) and master (control bit 4), and the slave-select input is configured as an input and is low, the block clears control bit 4, stops the serial clock low and sets the completion flag.
- R10: Status bits 5 to 1 always read 0. Status bit 0 is the double-speed bit and can be read and written.
- R11: A data write while the block is not master starts no transfer. No serial clock edge and no completion flag follow, whatever the rate bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is strobed |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt service acknowledge |
| irq | output | 1 | Interrupt request |
| ss_is_input | input | 1 | Slave-select pin configured as input |
| ss_n_in | input | 1 | Slave-select pin level |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Every rate code is run with both settings of the double-speed bit. Each run measures the cycle count from the data write to the interrupt request, so that a wrong divisor entry or a lost half-period shows up as a wrong count. Two byte patterns are used in each configuration, an alternating pattern and an asymmetric one. Together with an independent byte returned on MISO, they separate bit-order errors, sampling-edge errors and swapped transmit and receive paths. Separate sequences check that the flags clear only when a data access follows a status read, that a mid-transfer write raises the collision flag without disturbing the transfer, that a slave-select fault aborts the shift, and that a write while not master produces no clock activity.

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          gie,
  input  logic          irq_ack,
  output logic          irq,
  input  logic          ss_is_input,
  input  logic          ss_n_in,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);
  localparam int CW = 7;
  localparam int BW = $clog2(DW);

  logic [DW-1:0] ctrl, shreg, rxbuf;
  logic          dbl, done, coll, arm, busy, samp;
  logic [CW-1:0] cnt, half;
  logic [BW-1:0] bitcnt;

  wire wr_ctrl  = bus_sel && bus_wr && bus_addr == 2'd0;
  wire wr_stat  = bus_sel && bus_wr && bus_addr == 2'd1;
  wire rd_stat  = bus_sel && bus_rd && bus_addr == 2'd1;
  wire wr_data  = bus_sel && bus_wr && bus_addr == 2'd2;
  wire rd_data  = bus_sel && bus_rd && bus_addr == 2'd2;
  wire data_acc = wr_data || rd_data;
  wire enabled  = ctrl[6];
  wire master   = ctrl[4];
  wire ss_fault = enabled && master && ss_is_input && !ss_n_in;
  wire start    = wr_data && !busy && enabled && master && !ss_fault;
  wire tick     = busy && cnt == half - 1'b1;
  wire finish   = tick && sck && bitcnt == BW'(DW - 1);
  wire clr      = data_acc && arm;

  always_comb
    case ({dbl, ctrl[1:0]})
      3'b000:  half = CW'(2);
      3'b001:  half = CW'(8);
      3'b010:  half = CW'(32);
      3'b011:  half = CW'(64);
      3'b100:  half = CW'(1);
      3'b101:  half = CW'(4);
      3'b110:  half = CW'(16);
      default: half = CW'(32);
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; dbl <= 1'b0; done <= 1'b0; coll <= 1'b0; arm <= 1'b0;
      busy <= 1'b0; sck <= 1'b0; samp <= 1'b0; cnt <= '0; bitcnt <= '0;
      shreg <= '0; rxbuf <= '0;
    end else begin
      if (ss_fault)     ctrl[4] <= 1'b0;
      else if (wr_ctrl) ctrl <= bus_wdata;
      if (wr_stat) dbl <= bus_wdata[0];

      if (rd_stat)       arm <= done || coll;
      else if (data_acc) arm <= 1'b0;

      if (ss_fault) begin
        busy <= 1'b0; sck <= 1'b0; cnt <= '0;
      end else if (start) begin
        busy <= 1'b1; sck <= 1'b0; cnt <= '0; bitcnt <= '0; shreg <= bus_wdata;
      end else if (busy) begin
        if (tick) begin
          cnt <= '0;
          sck <= ~sck;
          if (!sck) samp <= miso;
          else begin
            shreg  <= {shreg[DW-2:0], samp};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BW'(DW - 1)) begin
              busy  <= 1'b0;
              rxbuf <= {shreg[DW-2:0], samp};
            end
          end
        end else cnt <= cnt + 1'b1;
      end

      if (finish || ss_fault)  done <= 1'b1;
      else if (irq_ack || clr) done <= 1'b0;

      if (wr_data && busy) coll <= 1'b1;
      else if (clr)        coll <= 1'b0;
    end
  end

  assign mosi = shreg[DW-1];
  assign irq  = done && ctrl[7] && gie;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd)
      case (bus_addr)
        2'd0:    bus_rdata = ctrl;
        2'd1:    bus_rdata = {done, coll, {(DW-3){1'b0}}, dbl};
        2'd2:    bus_rdata = rxbuf;
        default: bus_rdata = '0;
      endcase
  end

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R5
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(finish || ss_fault));
  // R6
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !finish && !ss_fault |=> !done);
  // R8
  coll_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll) |-> $past(wr_data && busy));
  // R9
  mstr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master) |-> $past(ss_fault || wr_ctrl));
endmodule

// File: tb/tb_spi_master_ctrl.sv
module tb_spi_master_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic gie = 1, irq_ack = 0, irq, ss_is_input = 0, ss_n_in = 1;
  logic sck, mosi, miso;
  int checks = 0, errors = 0;
  int rises = 0, falls = 0, base = 0;
  logic [7:0] cap = 0, sl = 0;

  always #2 clk = ~clk;

  spi_master_ctrl dut (.clk, .rst_n, .bus_sel, .bus_wr, .bus_rd, .bus_addr,
    .bus_wdata, .bus_rdata, .gie, .irq_ack, .irq, .ss_is_input, .ss_n_in,
    .sck, .mosi, .miso);

  always @(posedge sck) begin cap <= {cap[6:0], mosi}; rises <= rises + 1; end
  always @(negedge sck) falls <= falls + 1;
  assign miso = (falls - base < 8) ? sl[7 - (falls - base)] : 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(posedge clk); #1; bus_sel = 0; bus_rd = 0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  function automatic int divisor(input int dbl, input int r);
    int b = (r == 3) ? 128 : (4 << (2 * r));
    return dbl ? b / 2 : b;
  endfunction

  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, output int n);
    sl = rx; base = falls;
    wr(2, tx);
    n = 0;
    while (!irq && n < 5000) begin @(posedge clk); #1 n++; end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); chk("R1 ctrl", v, 8'h00);
    rd(1, v); chk("R1 status", v, 8'h00);
    chk("R1 sck", sck, 0);

    wr(1, 8'hFF); rd(1, v); chk("R10 status set", v, 8'h01);
    wr(1, 8'h00); rd(1, v); chk("R10 status clr", v, 8'h00);

    for (int d = 0; d < 2; d++)
      for (int r = 0; r < 4; r++)
        for (int p = 0; p < 2; p++) begin
          logic [7:0] tx = p ? 8'h1D : 8'hA5;
          logic [7:0] rx = p ? 8'hC6 : 8'h3B;
          wr(1, 8'(d));
          wr(0, 8'hD0 | 8'(r));
          xfer(tx, rx, n);
          chk(d ? "R3 divisor" : "R2 divisor", n, 8 * divisor(d, r));
          chk("R4 mosi msb first", cap, tx);
          rd(2, v); chk("R4 received", v, rx);
          chk("R7 no clear without status read", irq, 1);
          ack(); #1 chk("R6 ack clears", irq, 0);
        end

    wr(1, 8'h00); wr(0, 8'hD3);
    xfer(8'h5A, 8'h81, n);
    rd(2, v); chk("R7 flag kept", irq, 1);
    rd(1, v); chk("R5 done bit", v, 8'h80);
    rd(2, v); #1 chk("R7 cleared", irq, 0);
    rd(1, v); chk("R7 status after clear", v, 8'h00);

    sl = 8'h00; base = falls;
    wr(2, 8'hE1);
    repeat (50) @(posedge clk);
    wr(2, 8'h3C);
    n = 0;
    while (!irq && n < 5000) begin @(posedge clk); #1 n++; end
    chk("R8 byte unchanged", cap, 8'hE1);
    rd(1, v); chk("R8 coll bit", v, 8'hC0);
    rd(2, v); rd(1, v); chk("R8 coll cleared", v, 8'h00);

    wr(2, 8'h77);
    repeat (100) @(posedge clk);
    r0 = rises;
    @(negedge clk); ss_is_input = 1; ss_n_in = 0;
    repeat (2) @(negedge clk);
    chk("R9 sck low", sck, 0);
    chk("R9 done", irq, 1);
    rd(0, v); chk("R9 master cleared", v, 8'hC3);
    repeat (1200) @(posedge clk); #1;
    chk("R9 shift aborted", rises - r0, 0);
    @(negedge clk); ss_n_in = 1; ss_is_input = 0;
    ack();

    wr(0, 8'hC1);
    r0 = rises;
    wr(2, 8'h99);
    repeat (600) @(posedge clk); #1;
    chk("R11 no clock", rises - r0, 0);
    chk("R11 no done", irq, 0);
    rd(1, v); chk("R11 status", v, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule